// File: doc/BRIEF.md
# Single-to-Dual PWM Phase Splitter

This block turns one pulse-width-modulated control line into two phase outputs. This lets a multiphase controller run twice as many power phases as it has PWM pins. The input arrives already resolved into three levels: low, high or a mid-level window. The block also receives a resolved operating-mode code and a per-pulse request for extra on-time. Each output is a two-bit code: driven low, driven high or released (tri-state).

In the two interleaving modes, successive input pulses are steered to alternate outputs, so each phase runs at half the input rate. The falling edge of each output can be held back by a requested number of clock ticks. In the second interleaving mode a fixed delay is added on top of that, and this mode is accepted only after its code has been seen on four input pulses in a row. In synchronous mode both outputs copy every pulse.

The block also handles the restart rules. After enable, or after a long mid-level on the input, both outputs stay released until a genuine leading edge arrives. An overvoltage flag can pull both outputs low during that wait. All times are counted in ticks of the system clock, and the outputs are registered one tick behind the sampled inputs.

Top module: `pwm_phase_splitter`

## Requirements
- R1: Output codes are 00 low, 01 high, 10 released; 11 never appears. During reset, and on any tick after the mode code was 00 (off), both outputs are 10. Outputs follow the sampled inputs by one clock.
- R2: Input levels are 00 low, 01 high, 10 mid. Mode 01 is interleave-1, mode 10 is interleave-2 and mode 11 is synchronous. In interleave modes each leading edge turns on one output, alternating A, B, A and so on. The first pulse after a restart goes to A. The output stays high while the input is high.
- R3: In synchronous mode every leading edge turns both outputs on, and each input fall turns both off on the same tick, with no extension.
- R4: After enable, both outputs stay 10 until a leading edge arrives. A leading edge is a high sample whose last non-mid sample was low, or the first high after a hold-off trip. An input already high when enable returns does not count.
- R5: While waiting for that leading edge with the block enabled, an asserted overvoltage flag drives both outputs low (00) instead of 10.
- R6: HOLDOFF consecutive mid samples release both outputs and restart the wait, with the next pulse going to A. Fewer mid samples leave both outputs and all timing unchanged, and a high-mid-high sequence starts no new pulse.
- R7: In interleave-1, an output falls min(ext_req, VAR_MAX) ticks after the tick on which its input fall is seen. The request is sampled at the fall.
- R8: In interleave-2, the delay is FIX_EXT plus min(ext_req, VAR_MAX) ticks.
- R9: Interleave-2 takes effect only on the QUAL-th consecutive leading edge that sees its code. Until then the previous interleave or synchronous behaviour stays in force. After a disable, that previous behaviour is interleave-1. Any other code on a leading edge restarts the count.
- R10: The mode code is applied only at leading edges, except for off. A pulse ends with the extension rule of the mode it started in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_lvl | input | 2 | Resolved input level (00 low, 01 high, 10 mid) |
| mode_code | input | 2 | Resolved mode (00 off, 01 interleave-1, 10 interleave-2, 11 synchronous) |
| ovp_fault | input | 1 | Overvoltage flag |
| ext_req | input | REQ_W | Requested variable extension in ticks |
| out_a | output | 2 | Phase A code |
| out_b | output | 2 | Phase B code |

## Verification
The assertions assume that pwm_lvl never carries the unused code 11. They also assume that the inputs change only between clock edges, so one sample per tick is meaningful. The bench only ever drives the three legal levels, and it changes inputs on the falling clock edge. It compares against a behavioural model every tick. The stimulus deliberately includes requests above VAR_MAX, a mode change in the middle of a pulse, and an interrupted interleave-2 qualification.

// File: rtl/psplit_pkg.sv
package psplit_pkg;
  localparam logic [1:0] LV_LOW  = 2'b00;
  localparam logic [1:0] LV_HIGH = 2'b01;
  localparam logic [1:0] LV_MID  = 2'b10;

  localparam logic [1:0] OC_LOW  = 2'b00;
  localparam logic [1:0] OC_HIGH = 2'b01;
  localparam logic [1:0] OC_REL  = 2'b10;

  localparam logic [1:0] MD_OFF  = 2'b00;
  localparam logic [1:0] MD_IL1  = 2'b01;
  localparam logic [1:0] MD_IL2  = 2'b10;
  localparam logic [1:0] MD_SYNC = 2'b11;
endpackage

// File: rtl/psplit_edge_det.sv
module psplit_edge_det
  import psplit_pkg::*;
#(
  parameter int HOLDOFF = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lvl,
  output logic       rise,
  output logic       fall,
  output logic       mid,
  output logic       trip
);
  localparam int CW = $clog2(HOLDOFF + 1);

  logic          last_hi_q;
  logic [CW-1:0] mid_cnt_q;

  assign mid  = (lvl == LV_MID);
  assign rise = (lvl == LV_HIGH) && !last_hi_q;
  assign fall = (lvl == LV_LOW) && last_hi_q;
  assign trip = mid && (mid_cnt_q == CW'(HOLDOFF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      last_hi_q <= 1'b0;
      mid_cnt_q <= '0;
    end else if (trip) begin
      last_hi_q <= 1'b0;
      mid_cnt_q <= '0;
    end else if (mid) begin
      mid_cnt_q <= mid_cnt_q + 1'b1;
    end else begin
      mid_cnt_q <= '0;
      last_hi_q <= (lvl == LV_HIGH);
    end
  end
endmodule

// File: rtl/psplit_mode_qual.sv
module psplit_mode_qual
  import psplit_pkg::*;
#(
  parameter int QUAL = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       go,
  input  logic [1:0] code,
  output logic [1:0] eff_sel,
  output logic [1:0] eff_q
);
  localparam int QW = $clog2(QUAL + 1);

  logic [QW-1:0] seen_q;
  logic [QW-1:0] seen_d;

  always_comb begin
    eff_sel = eff_q;
    seen_d  = seen_q;
    if (go) begin
      if (code == MD_IL2) begin
        seen_d = (seen_q >= QW'(QUAL)) ? seen_q : seen_q + 1'b1;
        if (seen_d >= QW'(QUAL)) eff_sel = MD_IL2;
      end else begin
        seen_d  = '0;
        eff_sel = code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      eff_q  <= MD_IL1;
      seen_q <= '0;
    end else begin
      eff_q  <= eff_sel;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/psplit_chan.sv
module psplit_chan
  import psplit_pkg::*;
#(
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          force_low,
  input  logic          freeze,
  input  logic          start,
  input  logic          stop,
  input  logic [EW-1:0] ext_len,
  output logic [1:0]    out_code
);
  logic          on_q, on_d;
  logic [EW-1:0] cnt_q, cnt_d;
  logic [1:0]    code_d;

  always_comb begin
    on_d   = on_q;
    cnt_d  = cnt_q;
    code_d = out_code;
    if (clr) begin
      on_d   = 1'b0;
      cnt_d  = '0;
      code_d = force_low ? OC_LOW : OC_REL;
    end else if (!freeze) begin
      if (start) begin
        on_d  = 1'b1;
        cnt_d = '0;
      end else if (stop && on_q && cnt_q == '0) begin
        if (ext_len == '0) on_d = 1'b0;
        else cnt_d = ext_len;
      end else if (cnt_q != '0) begin
        if (cnt_q == EW'(1)) on_d = 1'b0;
        cnt_d = cnt_q - 1'b1;
      end
      code_d = on_d ? OC_HIGH : OC_LOW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q     <= 1'b0;
      cnt_q    <= '0;
      out_code <= OC_REL;
    end else begin
      on_q     <= on_d;
      cnt_q    <= cnt_d;
      out_code <= code_d;
    end
  end
endmodule

// File: rtl/pwm_phase_splitter.sv
module pwm_phase_splitter
  import psplit_pkg::*;
#(
  parameter int HOLDOFF = 6,
  parameter int FIX_EXT = 12,
  parameter int VAR_MAX = 7,
  parameter int REQ_W   = 4,
  parameter int QUAL    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       pwm_lvl,
  input  logic [1:0]       mode_code,
  input  logic             ovp_fault,
  input  logic [REQ_W-1:0] ext_req,
  output logic [1:0]       out_a,
  output logic [1:0]       out_b
);
  localparam int NCH = 2;
  localparam int EW  = $clog2(FIX_EXT + VAR_MAX + 1);

  logic       en, rise, fall, mid, trip, go;
  logic       wait_q, wait_d, sel_q;
  logic [1:0] eff_sel, eff_q;
  logic [EW-1:0] var_ext, ext_len;
  logic [NCH-1:0] start;
  logic [1:0] ch_out [NCH];

  assign en = (mode_code != MD_OFF);
  assign go = en && rise;

  psplit_edge_det #(.HOLDOFF(HOLDOFF)) edge_i (
    .clk(clk), .rst(rst), .lvl(pwm_lvl),
    .rise(rise), .fall(fall), .mid(mid), .trip(trip)
  );

  psplit_mode_qual #(.QUAL(QUAL)) qual_i (
    .clk(clk), .rst(rst), .en(en), .go(go), .code(mode_code),
    .eff_sel(eff_sel), .eff_q(eff_q)
  );

  always_comb begin
    if (!en || trip)      wait_d = 1'b1;
    else if (wait_q && go) wait_d = 1'b0;
    else                  wait_d = wait_q;
  end

  always_comb begin
    if (int'(ext_req) > VAR_MAX) var_ext = EW'(VAR_MAX);
    else                         var_ext = EW'(ext_req);
    case (eff_q)
      MD_IL2:  ext_len = var_ext + EW'(FIX_EXT);
      MD_IL1:  ext_len = var_ext;
      default: ext_len = '0;
    endcase
  end

  assign start[0] = go && ((eff_sel == MD_SYNC) || !sel_q);
  assign start[1] = go && ((eff_sel == MD_SYNC) || sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= 1'b1;
      sel_q  <= 1'b0;
    end else begin
      wait_q <= wait_d;
      if (wait_d)                          sel_q <= 1'b0;
      else if (go && eff_sel != MD_SYNC)   sel_q <= ~sel_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    psplit_chan #(.EW(EW)) chan_i (
      .clk(clk), .rst(rst),
      .clr(wait_d),
      .force_low(en && ovp_fault),
      .freeze(mid && !wait_q),
      .start(start[c]),
      .stop(fall),
      .ext_len(ext_len),
      .out_code(ch_out[c])
    );
  end

  assign out_a = ch_out[0];
  assign out_b = ch_out[1];
endmodule

// File: rtl/pwm_phase_splitter_chk.sv
module pwm_phase_splitter_chk
  import psplit_pkg::*;
#(
  parameter int REQ_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       pwm_lvl,
  input logic [1:0]       mode_code,
  input logic             ovp_fault,
  input logic [REQ_W-1:0] ext_req,
  input logic [1:0]       out_a,
  input logic [1:0]       out_b
);
  a_r1_legal_codes: assert property (@(posedge clk) disable iff (rst)
    (out_a != 2'b11) && (out_b != 2'b11));

  a_r1_off_releases: assert property (@(posedge clk) disable iff (rst)
    (mode_code == MD_OFF) |=> (out_a == OC_REL && out_b == OC_REL));

  a_r2_edge_drives: assert property (@(posedge clk) disable iff (rst)
    ($past(pwm_lvl) == LV_LOW && pwm_lvl == LV_HIGH && mode_code != MD_OFF)
    |=> (out_a == OC_HIGH || out_b == OC_HIGH));

  a_r4_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_code != MD_OFF && pwm_lvl != LV_HIGH && !ovp_fault &&
     out_a == OC_REL && out_b == OC_REL)
    |=> (out_a == OC_REL && out_b == OC_REL));

  a_r5_fault_low: assert property (@(posedge clk) disable iff (rst)
    (mode_code != MD_OFF && ovp_fault && pwm_lvl == LV_LOW &&
     out_a == OC_REL && out_b == OC_REL)
    |=> (out_a == OC_LOW && out_b == OC_LOW));
endmodule

bind pwm_phase_splitter pwm_phase_splitter_chk #(.REQ_W(REQ_W)) chk_i (.*);

// File: tb/pwm_phase_splitter_tb_top.sv
module pwm_phase_splitter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLDOFF = 6, FIX_EXT = 12, VAR_MAX = 7, REQ_W = 4, QUAL = 4;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] pwm_lvl = 2'b00;
  logic [1:0] mode_code = 2'b00;
  logic ovp_fault = 1'b0;
  logic [REQ_W-1:0] ext_req = '0;
  logic [1:0] out_a, out_b;

  int checks = 0, errors = 0, cycles = 0;
  string cur = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_phase_splitter #(.HOLDOFF(HOLDOFF), .FIX_EXT(FIX_EXT), .VAR_MAX(VAR_MAX),
                       .REQ_W(REQ_W), .QUAL(QUAL)) dut_i (
    .clk(clk), .rst(rst), .pwm_lvl(pwm_lvl), .mode_code(mode_code),
    .ovp_fault(ovp_fault), .ext_req(ext_req), .out_a(out_a), .out_b(out_b));

  // behavioural reference
  int m_wait, m_prev, m_midcnt, m_sel, m_eff, m_q;
  int m_on [2];
  int m_cnt [2];
  int m_exp [2];

  always @(posedge clk) begin
    if (rst) begin
      m_wait = 1; m_prev = 0; m_midcnt = 0; m_sel = 0; m_eff = 1; m_q = 0;
      for (int c = 0; c < 2; c++) begin m_on[c] = 0; m_cnt[c] = 0; m_exp[c] = 2; end
    end else begin
      int en, hi, lo, md, rs, fl, trip, go, nwait, use_eff, ext, v;
      int st [2];
      en = (mode_code != 0); hi = (pwm_lvl == 1); lo = (pwm_lvl == 0); md = (pwm_lvl == 2);
      rs = hi && !m_prev; fl = lo && m_prev;
      trip = md && (m_midcnt == HOLDOFF - 1);
      go = en && rs;
      nwait = (!en || trip) ? 1 : ((m_wait && go) ? 0 : m_wait);
      v = (int'(ext_req) > VAR_MAX) ? VAR_MAX : int'(ext_req);
      ext = (m_eff == 2) ? FIX_EXT + v : (m_eff == 1) ? v : 0;
      use_eff = m_eff;
      if (go) begin
        if (mode_code == 2) begin
          if (m_q < QUAL) m_q = m_q + 1;
          if (m_q >= QUAL) use_eff = 2;
        end else begin
          m_q = 0; use_eff = int'(mode_code);
        end
      end
      st[0] = go && (use_eff == 3 || m_sel == 0);
      st[1] = go && (use_eff == 3 || m_sel == 1);
      for (int c = 0; c < 2; c++) begin
        if (nwait) begin
          m_on[c] = 0; m_cnt[c] = 0; m_exp[c] = (en && ovp_fault) ? 0 : 2;
        end else if (!(md && !m_wait)) begin
          if (st[c]) begin m_on[c] = 1; m_cnt[c] = 0; end
          else if (fl && m_on[c] && m_cnt[c] == 0) begin
            if (ext == 0) m_on[c] = 0; else m_cnt[c] = ext;
          end else if (m_cnt[c] > 0) begin
            if (m_cnt[c] == 1) m_on[c] = 0;
            m_cnt[c] = m_cnt[c] - 1;
          end
          m_exp[c] = m_on[c];
        end
      end
      if (nwait) m_sel = 0; else if (go && use_eff != 3) m_sel = 1 - m_sel;
      m_eff = en ? use_eff : 1;
      if (!en) m_q = 0;
      if (trip) begin m_prev = 0; m_midcnt = 0; end
      else if (md) m_midcnt = m_midcnt + 1;
      else begin m_midcnt = 0; m_prev = hi; end
      m_wait = nwait;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (int'(out_a) != m_exp[0] || int'(out_b) != m_exp[1]) begin
        errors++;
        $display("FAIL %s cycle %0d: a=%0d b=%0d expected a=%0d b=%0d",
                 cur, cycles, out_a, out_b, m_exp[0], m_exp[1]);
      end
    end
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic hold(input logic [1:0] lvl, input int n);
    pwm_lvl = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int h, input int l);
    hold(2'b01, h);
    hold(2'b00, l);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (out_a != 2'b10 || out_b != 2'b10) begin
      errors++;
      $display("FAIL R1 reset: a=%0d b=%0d expected 2 2", out_a, out_b);
    end
    rst = 1'b0;
    cur = "R1"; hold(2'b00, 3);
    mode_code = 2'b01;
    cur = "R4"; hold(2'b00, 4); hold(2'b10, 2); hold(2'b00, 3);
    cur = "R5"; ovp_fault = 1'b1; hold(2'b00, 3); ovp_fault = 1'b0; hold(2'b00, 2);
    cur = "R2"; for (int i = 0; i < 4; i++) pulse(5, 8);
    cur = "R7"; ext_req = 4'd3; pulse(5, 10); pulse(5, 10);
    ext_req = 4'd15; pulse(5, 12); pulse(5, 12);
    cur = "R6"; ext_req = 4'd2;
    hold(2'b01, 3); hold(2'b10, 3); hold(2'b01, 2); hold(2'b00, 10);
    hold(2'b01, 3); hold(2'b10, 8); hold(2'b00, 4);
    pulse(3, 10); pulse(3, 10);
    cur = "R10"; ext_req = 4'd4; hold(2'b01, 3); mode_code = 2'b11; hold(2'b01, 2); hold(2'b00, 10);
    cur = "R3"; for (int i = 0; i < 3; i++) pulse(4, 6);
    cur = "R8/R9"; mode_code = 2'b10; ext_req = 4'd2;
    for (int i = 0; i < 6; i++) pulse(4, 25);
    mode_code = 2'b01; pulse(4, 25);
    mode_code = 2'b10; pulse(4, 25); pulse(4, 25);
    mode_code = 2'b01; pulse(4, 25);
    mode_code = 2'b10; ext_req = 4'd9; for (int i = 0; i < 5; i++) pulse(4, 25);
    cur = "R1"; hold(2'b01, 3); mode_code = 2'b00; hold(2'b01, 4);
    cur = "R4"; mode_code = 2'b01; hold(2'b01, 3); hold(2'b00, 2); pulse(4, 10); pulse(4, 10);
    finish_run();
  end
endmodule